// File: doc/BRIEF.md
# Bit-Serial PHY Management Responder

This block plays the management side of an Ethernet PHY that a host drives one bit at a time by writing a 32-bit control word. Some control words carry a single management input bit. Others ask for a single output bit. Every other word is just stored. The responder decodes management frames from these input bits. A frame has an idle/preamble phase, a start pattern, a two-bit opcode, a PHY address, a register address and, for writes, a turnaround pair and 16 data bits. The responder keeps an array of 16-bit registers indexed by PHY address and register address, and it answers reads from that array.

A read frame does not drive data while the frame is still arriving. When the last register-address bit comes in, the register value is loaded into a 32-bit output shifter, and the decoder returns to idle. The host then sends read strobes. Each strobe copies the shifter's top bit into the receive bit of the control word and shifts the shifter left. The load position puts one dummy zero ahead of the data. Register address 1 never returns stored data. It returns a link-status word computed from the `link_up` input.

Control word bit fields (the positions are part of the behaviour): bit 13 write-enable, bit 14 read-enable, bit 16 management clock, bit 17 transmitted data, bit 18 management-read select, bit 19 received data.

Top module: `mgmt_phy_responder`

## Requirements
- R1: In idle, an input bit of 1 leaves the decoder idle, so any number of preamble ones is absorbed. An input bit of 0 leaves idle and clears the captured PHY address, register address and data.
- R2: The start pattern is 0 then 1. After the start, opcode bits 1,0 select a read and 0,1 select a write. Opcode 1,1 or 0,0 returns the decoder to idle, and no register is read or written.
- R3: After the opcode, 5 PHY-address bits and then 5 register-address bits are taken most significant bit first. Every one of the 32×32 locations is addressed separately.
- R4: On the last register-address bit of a read, the 16-bit value is placed at bits 30..15 of the 32-bit output shifter. The first strobe after that returns a dummy 0. The next 16 strobes return the value MSB first, and later strobes return 0.
- R5: A write needs turnaround bits 1 then 0 after the register address. It then takes 16 data bits MSB first and stores them at the addressed location on the 16th bit.
- R6: A read of register address 1, at any PHY address, returns 0x0004 when `link_up` is high and 0x0000 when it is low, whatever was written there.
- R7: A read strobe is a write whose value, with bit 17 ignored, equals exactly 0x00054000 (bits 18, 16, 14). The stored control word then takes the written value with bit 19 replaced by the shifter's top bit.
- R8: An input bit is a write whose value, with bit 17 ignored, equals exactly 0x00012000 (bits 16, 13), and bit 17 is the data. Any other written value is stored verbatim as the control word and does not change the decoder or the output shifter.
- R9: After reset the control word is 0, the output shifter is 0 and every register reads 0.
- R10: A wrong turnaround bit (0 first, or 1 second) aborts the write to idle and leaves the addressed register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link present. Sets the value read back from register address 1 |
| host_wr | input | 1 | Host write strobe for the control word |
| host_wdata | input | 32 | Control word value being written |
| ctl_word | output | 32 | Current control word, with bit 19 carrying the last strobed-out bit |

## Verification
A decoder state that has slipped by one bit does not show up while a frame is arriving. It shows up only at the next strobe sequence: the read value comes out rotated, or a write lands in the wrong location and is seen on a later read. So every location is written with a value unique to its address and then read back in full. An aborted frame that is wrongly taken as valid changes a register, and this shows on the readback of that register right after the abort. A strobe or junk word that is decoded wrongly shows in `ctl_word` in the very next cycle.

// File: rtl/mgmt_pkg.sv
// Package: shared constants and the decoder state type for the management responder.
// Assumes a control word of at least 20 bits; bit positions are fixed by the host protocol.
package mgmt_pkg;
    localparam int CTL_CLK_BIT  = 16;
    localparam int CTL_TXD_BIT  = 17;
    localparam int CTL_MRD_BIT  = 18;
    localparam int CTL_RXD_BIT  = 19;
    localparam int CTL_REN_BIT  = 14;
    localparam int CTL_WEN_BIT  = 13;
    localparam int LINK_REG_ADR = 1;
    localparam int LINK_BIT_POS = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_OP,
        ST_OP_RD,
        ST_OP_WR,
        ST_PHY,
        ST_REG,
        ST_TA1,
        ST_TA2,
        ST_DATA
    } frame_state_e;
endpackage

// File: rtl/mgmt_ctl_decode.sv
// Module: classifies a host control-word write as an input bit, a read strobe or neither.
// Assumes CTL_W >= 20. Bit 17 is masked off before the exact compare.
module mgmt_ctl_decode
    import mgmt_pkg::*;
#(
    parameter int CTL_W = 32
) (
    input  logic             host_wr,
    input  logic [CTL_W-1:0] host_wdata,
    output logic             take_bit,
    output logic             bit_val,
    output logic             pop_bit
);
    localparam logic [CTL_W-1:0] TXD_MASK = CTL_W'(1) << CTL_TXD_BIT;
    localparam logic [CTL_W-1:0] IN_PAT   = (CTL_W'(1) << CTL_CLK_BIT) | (CTL_W'(1) << CTL_WEN_BIT);
    localparam logic [CTL_W-1:0] POP_PAT  = (CTL_W'(1) << CTL_CLK_BIT) | (CTL_W'(1) << CTL_REN_BIT)
                                          | (CTL_W'(1) << CTL_MRD_BIT);

    logic [CTL_W-1:0] masked;

    // Purpose: compare the written word with bit 17 cleared against the two command patterns.
    always_comb begin
        masked   = host_wdata & ~TXD_MASK;
        take_bit = host_wr && (masked == IN_PAT);
        pop_bit  = host_wr && (masked == POP_PAT);
        bit_val  = host_wdata[CTL_TXD_BIT];
    end
endmodule

// File: rtl/mgmt_frame_fsm.sv
// Module: bit-serial management frame decoder. It consumes one bit per take_bit pulse and
// issues a read-load or a register write when a frame is complete.
// Assumes fields arrive MSB first; the field counter is sized for the widest field.
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_bit,
    input  logic              bit_val,
    output logic              rd_go,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [REG_AW-1:0] rd_reg_addr,
    output logic              wr_go,
    output logic [REG_AW-1:0] wr_reg_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int MAXF  = (DATA_W > PHY_AW) ? ((DATA_W > REG_AW) ? DATA_W : REG_AW)
                                             : ((PHY_AW > REG_AW) ? PHY_AW : REG_AW);
    localparam int CNT_W = $clog2(MAXF);
    localparam logic [CNT_W-1:0] PHY_LAST  = CNT_W'(PHY_AW - 1);
    localparam logic [CNT_W-1:0] REG_LAST  = CNT_W'(REG_AW - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    frame_state_e      state_q;
    logic              is_wr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PHY_AW-1:0] phy_q;
    logic [REG_AW-1:0] reg_q;
    logic [DATA_W-1:0] data_q;

    // Purpose: advance the frame decoder and capture the address and data fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            is_wr_q <= 1'b0;
            cnt_q   <= '0;
            phy_q   <= '0;
            reg_q   <= '0;
            data_q  <= '0;
        end else if (take_bit) begin
            case (state_q)
                ST_IDLE: begin
                    if (!bit_val) begin
                        state_q <= ST_START;
                        phy_q   <= '0;
                        reg_q   <= '0;
                        data_q  <= '0;
                    end
                end
                ST_START: state_q <= bit_val ? ST_OP : ST_IDLE;
                ST_OP:    state_q <= bit_val ? ST_OP_RD : ST_OP_WR;
                ST_OP_RD: begin
                    state_q <= bit_val ? ST_IDLE : ST_PHY;
                    is_wr_q <= 1'b0;
                    cnt_q   <= '0;
                end
                ST_OP_WR: begin
                    state_q <= bit_val ? ST_PHY : ST_IDLE;
                    is_wr_q <= 1'b1;
                    cnt_q   <= '0;
                end
                ST_PHY: begin
                    phy_q <= {phy_q[PHY_AW-2:0], bit_val};
                    if (cnt_q == PHY_LAST) begin
                        state_q <= ST_REG;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_REG: begin
                    reg_q <= {reg_q[REG_AW-2:0], bit_val};
                    if (cnt_q == REG_LAST) begin
                        state_q <= is_wr_q ? ST_TA1 : ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_TA1: state_q <= bit_val ? ST_TA2 : ST_IDLE;
                ST_TA2: begin
                    state_q <= bit_val ? ST_IDLE : ST_DATA;
                    cnt_q   <= '0;
                end
                ST_DATA: begin
                    data_q <= {data_q[DATA_W-2:0], bit_val};
                    if (cnt_q == DATA_LAST) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: flag frame completion and present the addresses including the bit arriving now.
    always_comb begin
        rd_go       = take_bit && (state_q == ST_REG) && (cnt_q == REG_LAST) && !is_wr_q;
        wr_go       = take_bit && (state_q == ST_DATA) && (cnt_q == DATA_LAST);
        phy_addr    = phy_q;
        rd_reg_addr = {reg_q[REG_AW-2:0], bit_val};
        wr_reg_addr = reg_q;
        wr_data     = {data_q[DATA_W-2:0], bit_val};
    end

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_bit && bit_val && state_q == ST_IDLE) |=> (state_q == ST_IDLE));

    assert_fields_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_bit && !bit_val && state_q == ST_IDLE) |=> (phy_q == '0 && reg_q == '0 && data_q == '0));

    assert_bad_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_bit && ((state_q == ST_OP_RD && bit_val) || (state_q == ST_OP_WR && !bit_val)))
        |=> (state_q == ST_IDLE));

    assert_ta_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_bit && ((state_q == ST_TA1 && !bit_val) || (state_q == ST_TA2 && bit_val)))
        |=> (state_q == ST_IDLE));

    assert_no_bit_no_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_bit |=> ($stable(state_q) && $stable(cnt_q) && $stable(phy_q)));

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PHY || state_q == ST_REG) |-> (cnt_q <= PHY_LAST || cnt_q <= REG_LAST));
endmodule

// File: rtl/mgmt_reg_file.sv
// Module: the PHY register array, one DATA_W word per PHY and register address, with the
// link-status register computed from link_up. Writes land on the clock edge of wr_go.
// Assumes a flop array that clears fully in reset; the read port is combinational.
module mgmt_reg_file
    import mgmt_pkg::*;
#(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              wr_go,
    input  logic [PHY_AW-1:0] wr_phy,
    input  logic [REG_AW-1:0] wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PHY_AW-1:0] rd_phy,
    input  logic [REG_AW-1:0] rd_reg,
    output logic [DATA_W-1:0] rd_val
);
    localparam int ADR_W   = PHY_AW + REG_AW;
    localparam int ENTRIES = 1 << ADR_W;

    logic [DATA_W-1:0] mem_q [ENTRIES];
    logic [ADR_W-1:0]  wr_idx;
    logic [ADR_W-1:0]  rd_idx;

    assign wr_idx = {wr_phy, wr_reg};
    assign rd_idx = {rd_phy, rd_reg};

    // Purpose: clear the array in reset, else store a completed write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_go) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Purpose: answer a read from the array, or from the link input for the status register.
    always_comb begin
        if (rd_reg == REG_AW'(LINK_REG_ADR)) begin
            rd_val = link_up ? (DATA_W'(1) << LINK_BIT_POS) : '0;
        end else begin
            rd_val = mem_q[rd_idx];
        end
    end

    assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (mem_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/mgmt_out_shift.sv
// Module: output shifter for read data. A load places the value one bit below the top, so the
// first pop yields a dummy zero; each pop then moves the word left by one.
// Assumes load and pop never coincide (they come from disjoint command patterns).
module mgmt_out_shift #(
    parameter int OUT_W  = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              pop,
    output logic              top_bit,
    output logic [OUT_W-1:0]  sh_word
);
    localparam int SH_POS = OUT_W - DATA_W - 1;

    logic [OUT_W-1:0] sh_q;

    // Purpose: load the read value at its fixed offset or shift one bit out per pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= OUT_W'(load_val) << SH_POS;
        end else if (pop) begin
            sh_q <= {sh_q[OUT_W-2:0], 1'b0};
        end
    end

    assign top_bit = sh_q[OUT_W-1];
    assign sh_word = sh_q;

    assert_dummy_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sh_q[OUT_W-1] == 1'b0));

    assert_hold_when_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !pop) |=> $stable(sh_q));

    assert_not_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && pop));
endmodule

// File: rtl/mgmt_phy_responder.sv
// Module: top of the bit-serial PHY management responder. It holds the host control word,
// classifies each write, feeds the frame decoder, the register array and the output shifter,
// and returns strobed read bits in bit 19 of the control word.
// Assumes one host write per clock at most; synchronous active-low reset.
module mgmt_phy_responder
    import mgmt_pkg::*;
#(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16,
    parameter int CTL_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic             host_wr,
    input  logic [CTL_W-1:0] host_wdata,
    output logic [CTL_W-1:0] ctl_word
);
    localparam int OUT_W  = 2 * DATA_W;
    localparam int SH_POS = OUT_W - DATA_W - 1;

    logic              take_bit;
    logic              bit_val;
    logic              pop_bit;
    logic              rd_go;
    logic              wr_go;
    logic [PHY_AW-1:0] phy_addr;
    logic [REG_AW-1:0] rd_reg_addr;
    logic [REG_AW-1:0] wr_reg_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_val;
    logic              top_bit;
    logic [OUT_W-1:0]  sh_word;
    logic [CTL_W-1:0]  ctl_q;

    mgmt_ctl_decode #(.CTL_W(CTL_W)) u_decode (
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .take_bit   (take_bit),
        .bit_val    (bit_val),
        .pop_bit    (pop_bit)
    );

    mgmt_frame_fsm #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_bit    (take_bit),
        .bit_val     (bit_val),
        .rd_go       (rd_go),
        .phy_addr    (phy_addr),
        .rd_reg_addr (rd_reg_addr),
        .wr_go       (wr_go),
        .wr_reg_addr (wr_reg_addr),
        .wr_data     (wr_data)
    );

    mgmt_reg_file #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .wr_go   (wr_go),
        .wr_phy  (phy_addr),
        .wr_reg  (wr_reg_addr),
        .wr_data (wr_data),
        .rd_phy  (phy_addr),
        .rd_reg  (rd_reg_addr),
        .rd_val  (rd_val)
    );

    mgmt_out_shift #(.OUT_W(OUT_W), .DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_go),
        .load_val (rd_val),
        .pop      (pop_bit),
        .top_bit  (top_bit),
        .sh_word  (sh_word)
    );

    // Purpose: hold the last written control word, inserting the popped bit on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (host_wr) begin
            ctl_q <= host_wdata;
            if (pop_bit) begin
                ctl_q[CTL_RXD_BIT] <= top_bit;
            end
        end
    end

    assign ctl_word = ctl_q;

    assert_rx_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_bit |=> (ctl_q[CTL_RXD_BIT] == $past(top_bit)));

    assert_plain_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !pop_bit) |=> (ctl_q == $past(host_wdata)));

    assert_link_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && rd_reg_addr == REG_AW'(LINK_REG_ADR)) |=>
        (sh_word[SH_POS +: DATA_W] == ($past(link_up) ? (DATA_W'(1) << LINK_BIT_POS) : '0)));
endmodule

// File: tb/test_mgmt_phy_responder.sv
module test_mgmt_phy_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b1;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] ctl_word;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    localparam logic [31:0] IN_WORD  = 32'h0001_2000;
    localparam logic [31:0] POP_WORD = 32'h0005_4000;

    always #4 clk = ~clk;

    mgmt_phy_responder i_mgmt_phy_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_up    (link_up),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .ctl_word   (ctl_word)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pattern(int p, int r);
        return 16'((p * 1057 + r * 73 + 16'h5a5) ^ (r << 11));
    endfunction

    task automatic put(logic [31:0] w);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = w;
        @(posedge clk);
        #1;
        host_wr = 1'b0;
    endtask

    task automatic send_bit(bit b);
        put(IN_WORD | (32'(b) << 17));
    endtask

    task automatic junk(logic [31:0] w, string tag);
        put(w);
        chk(ctl_word == w, tag, ctl_word, w);
    endtask

    task automatic pop(bit alt17, output bit b);
        logic [31:0] w;
        w = alt17 ? (POP_WORD | 32'h0002_0000) : POP_WORD;
        put(w);
        b = ctl_word[19];
        if (alt17) chk((ctl_word & ~32'h0008_0000) == w, "R7 strobe with bit17 stores word", ctl_word, w);
    endtask

    task automatic send_head(bit b0, bit b1, int p);
        send_bit(1); send_bit(1);
        send_bit(0); send_bit(1);
        send_bit(b0); send_bit(b1);
        for (int i = 4; i >= 0; i--) send_bit(p[i]);
    endtask

    task automatic wr_frame(int p, int r, logic [15:0] d, bit t0, bit t1);
        send_head(1'b0, 1'b1, p);
        for (int i = 4; i >= 0; i--) send_bit(r[i]);
        send_bit(t0); send_bit(t1);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
    endtask

    task automatic rd_frame(int p, int r, bit mix, logic [15:0] exp, string tag);
        bit b;
        logic [15:0] got;
        send_head(1'b1, 1'b0, p);
        if (mix) begin
            junk(IN_WORD | 32'h1, "R8 junk extra bit0");
            junk(32'h0000_2000, "R8 junk no clock");
            junk(32'h0009_2000, "R8 junk bit19 set");
        end
        for (int i = 4; i >= 0; i--) send_bit(r[i]);
        pop(mix, b);
        chk(b == 1'b0, "R4 dummy bit", int'(b), 0);
        got = '0;
        for (int i = 0; i < 16; i++) begin
            if (mix && i == 7) begin
                junk(POP_WORD | 32'h0000_0100, "R8 junk near strobe");
                junk(32'h0005_6000, "R8 junk both enables");
            end
            pop(mix && i == 3, b);
            got = {got[14:0], b};
        end
        chk(got == exp, tag, got, exp);
    endtask

    task automatic idle_ones(int n);
        for (int i = 0; i < n; i++) send_bit(1);
    endtask

    initial begin
        bit b;
        repeat (3) @(posedge clk);
        #1;
        chk(ctl_word == 32'h0, "R9 reset control word", ctl_word, 0);
        @(negedge clk);
        rst_n = 1'b1;
        pop(1'b0, b);
        chk(b == 1'b0 && ctl_word == POP_WORD, "R9 reset shifter", ctl_word, POP_WORD);
        rd_frame(3, 7, 1'b0, 16'h0, "R9 reset register");
        rd_frame(31, 30, 1'b0, 16'h0, "R9 reset register top");

        // R3 R5: write every location with an address-unique value
        for (int p = 0; p < 32; p++)
            for (int r = 0; r < 32; r++)
                wr_frame(p, r, pattern(p, r), 1'b1, 1'b0);
        // R3 R4 R6: read every location back
        for (int p = 0; p < 32; p++)
            for (int r = 0; r < 32; r++)
                rd_frame(p, r, 1'b0, (r == 1) ? 16'h0004 : pattern(p, r), (r == 1) ? "R6 link high" : "R3 R4 R5 readback");

        // R4: strobes beyond the data return zero
        pop(1'b0, b); chk(b == 1'b0, "R4 tail zero", int'(b), 0);
        pop(1'b0, b); chk(b == 1'b0, "R4 tail zero", int'(b), 0);

        // R6: link low
        link_up = 1'b0;
        rd_frame(9, 1, 1'b0, 16'h0000, "R6 link low");
        link_up = 1'b1;
        wr_frame(9, 1, 16'hffff, 1'b1, 1'b0);
        rd_frame(9, 1, 1'b0, 16'h0004, "R6 stored value ignored");

        // R2: bad opcodes do nothing
        send_head(1'b1, 1'b1, 5);
        idle_ones(40);
        send_head(1'b0, 1'b0, 5);
        idle_ones(40);
        rd_frame(5, 12, 1'b0, pattern(5, 12), "R2 bad opcode harmless");

        // R10: bad turnaround aborts
        wr_frame(6, 20, 16'h1234, 1'b0, 1'b0);
        idle_ones(40);
        rd_frame(6, 20, 1'b0, pattern(6, 20), "R10 turnaround 0,0");
        wr_frame(6, 21, 16'h4321, 1'b1, 1'b1);
        idle_ones(40);
        rd_frame(6, 21, 1'b0, pattern(6, 21), "R10 turnaround 1,1");

        // R1: long preamble absorbed
        idle_ones(50);
        wr_frame(17, 2, 16'hbeef, 1'b1, 1'b0);
        rd_frame(17, 2, 1'b1, 16'hbeef, "R1 R7 R8 long preamble and junk");

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule